// File: doc/BRIEF.md
# Dual Autoreload PWM Timer

This block is a timer with two 12-bit up-counters. Each one starts again from its own reload value when it passes 0xFFF. Counter 1 runs on every clock. Counter 2 runs only while it is selected as the time base of the second PWM pair. When it is deselected it holds its value, and it continues from that value when it is selected again.

There are four PWM outputs in two pairs. Each output is high while its time base is below the channel's 12-bit compare value. Counter 1 also has a capture register. It records the counter on either edge of one of two synchronized capture pins. A break input forces the selected pairs to 0. Which break enable governs the second pair depends on that pair's time base.

Software reaches the block through a byte-wide register bus of single-cycle strobes. A write takes effect at the clock edge where `bus_wr` is high. A read strobe `bus_rd` returns data on `bus_rdata` after that edge, and any side effect of the read happens at the same edge. The bus has no back-pressure: every strobe completes in one cycle.

Top module: `pwmt_timer`

## Requirements
- R1: Counter 1 increments on every clock. Counter 2 increments on every clock while MODE bit 0 is 1. A counter at 0xFFF goes next to its reload value (counter 1: 0x2 low, 0x3 high nibble; counter 2: 0x4 low, 0x5 high nibble). Counter 2 can be read at 0x10 (low byte) and 0x11 (high nibble).
- R2: Writing 1 to MODE bit 4 (counter 1) or bit 5 (counter 2) sets that counter's force bit and loads 0xFFF into the counter. The bit reads back as 1 until one clock after that counter's next overflow, and then clears. Writing 0 to the bit has no effect.
- R3: The counter 2 overflow flag (MODE bit 3, read-only) is set when counter 2 wraps. Any read of MODE at address 0x0 clears it. `ovf2_irq` is high exactly while the flag and MODE bit 2 are both 1.
- R4: With MODE bit 0 = 0, PWM2/3 use counter 1 and counter 2 holds its value. With bit 0 = 1, PWM2/3 use counter 2, which resumes from the held value.
- R5: Channel n has its compare value at 0x8+2n (low byte) and 0x9+2n (high nibble). Its output is 1 while its counter is below the compare value and 0 otherwise, one clock after the counter value.
- R6: MODE bit 1 selects the capture pin: 0 selects `cap_pin` and 1 selects `lcap_pin`. Each pin passes through a two-flop synchronizer. A rising or a falling edge of the selected pin copies counter 1 into the capture register. Edges on the pin that is not selected have no effect.
- R7: The capture register reads at 0x6 (low byte) and 0x7 (bits 3:0 are the high nibble, bit 7 is the capture flag). A capture sets the flag. While the flag is 1, further edges leave the register unchanged. Reading 0x6 clears the flag.
- R8: The break-enable register at 0x1 resets to 0x03. Bit 0 is the counter 1 enable and bit 1 the counter 2 enable. Bits 7:2 always read 0.
- R9: While `brk_in` is 1, PWM0/1 are 0 if enable bit 0 is set. PWM2/3 are 0 if enable bit 0 is set and MODE bit 0 = 0, or if enable bit 1 is set and MODE bit 0 = 1. The gating has no clock delay.
- R10: After reset all PWM outputs and `ovf2_irq` are 0. MODE, the capture register and its flag are 0, and the break-enable register is 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid after the read edge |
| cap_pin | input | 1 | Normal capture pin |
| lcap_pin | input | 1 | Long capture pin |
| brk_in | input | 1 | Break request, active high |
| pwm_o | output | 4 | PWM outputs, bit n is channel n |
| ovf2_irq | output | 1 | Counter 2 overflow interrupt request |

## Verification
The PWM outputs are measured as high-cycle counts over a 256-cycle window, using four compare values: zero, a quarter, three quarters and full scale. Each count depends on which counter drives the channel, so a wrong time base or a wrong comparison shows up as a count that differs from the expected one. Capture is tested with a rising edge and then a falling edge 20 cycles later, followed by a clear and a third edge exactly 100 cycles after the first. The difference between the two captured values shows whether the edge that arrived while the flag was set was ignored. The break input is applied under each combination of enable bits and PWM2/3 time base, which separates the routing of the two enables. The force bit is tested with counter 2 frozen, so that the bit stays set and a write of 0 can be shown to have no effect.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t A_MODE  = 5'h00;
  localparam addr_t A_BRK   = 5'h01;
  localparam addr_t A_RLD1L = 5'h02;
  localparam addr_t A_RLD1H = 5'h03;
  localparam addr_t A_RLD2L = 5'h04;
  localparam addr_t A_RLD2H = 5'h05;
  localparam addr_t A_CAPL  = 5'h06;
  localparam addr_t A_CAPH  = 5'h07;
  localparam addr_t A_CMP0  = 5'h08;
  localparam addr_t A_CNT2L = 5'h10;
  localparam addr_t A_CNT2H = 5'h11;
  // MODE bit positions
  localparam int M_SEL2  = 0;
  localparam int M_CSRC  = 1;
  localparam int M_IE2   = 2;
  localparam int M_OVF2  = 3;
  localparam int M_FRC1  = 4;
  localparam int M_FRC2  = 5;
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         force_set,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         force_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt;
  logic         force_q, done_q, load_top, wrap;

  assign load_top = force_q && !done_q && (cnt != TOP);
  assign wrap     = en && !load_top && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_top) begin
      cnt <= TOP;
    end else if (en) begin
      cnt <= wrap ? reload : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= force_q && wrap;
      if (force_set)   force_q <= 1'b1;
      else if (done_q) force_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt;
  assign wrap_o  = wrap;
  assign force_o = force_q;

  // R1
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == $past(reload));
  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_top) |=> $stable(cnt));
  // R2
  force_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_top |=> cnt == TOP);
  // R2
  force_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_q) |-> $past(done_q));
endmodule

// File: rtl/pwmt_capture.sv
module pwmt_capture #(
  parameter int W    = 12,
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic            src,
  input  logic [W-1:0]    cnt,
  input  logic            clr,
  output logic [W-1:0]    cap_o,
  output logic            flag_o
);
  logic [NPIN-1:0] edge_hit;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0;
      end else begin
        s1 <= pins[i]; s2 <= s1; prev <= s2;
      end
    end
    assign edge_hit[i] = s2 ^ prev;
  end

  logic         take;
  logic [W-1:0] cap;
  logic         flag;

  assign take = edge_hit[src] && !flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap  <= '0;
      flag <= 1'b0;
    end else begin
      if (take) cap <= cnt;
      if (take)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assign cap_o  = cap;
  assign flag_o = flag;

  // R7
  cap_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(cap));
  // R6
  cap_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit[src] && !flag) |=> (flag && cap == $past(cnt)));
endmodule

// File: rtl/pwmt_pwm_ch.sv
module pwmt_pwm_ch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= (cnt < cmp);
  end

  // R5
  duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= cmp) |=> !out_q);
  // R5
  duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < cmp) |=> out_q);
endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int N_CH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cap_pin,
  input  logic              lcap_pin,
  input  logic              brk_in,
  output logic [N_CH-1:0]   pwm_o,
  output logic              ovf2_irq
);
  localparam int HI_W = CNT_W - 8;
  localparam int HALF = N_CH / 2;

  function automatic logic [7:0] hi8(input logic [CNT_W-1:0] v);
    logic [7:0] r;
    r = '0;
    r[HI_W-1:0] = v[CNT_W-1:8];
    return r;
  endfunction

  logic             sel2_q, csrc_q, ie2_q, ovf2_q;
  logic [1:0]       brk_en_q;
  logic [CNT_W-1:0] rld1, rld2;
  logic [CNT_W-1:0] cmp_r [N_CH];

  logic             wr_mode, clr_ovf, clr_cap;
  logic [CNT_W-1:0] cnt1, cnt2, cap_val;
  logic             wrap1, wrap2, frc1, frc2, cap_flag;

  assign wr_mode = bus_wr && bus_addr == A_MODE;
  assign clr_ovf = bus_rd && bus_addr == A_MODE;
  assign clr_cap = bus_rd && bus_addr == A_CAPL;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel2_q   <= 1'b0;
      csrc_q   <= 1'b0;
      ie2_q    <= 1'b0;
      brk_en_q <= 2'b11;
      rld1     <= '0;
      rld2     <= '0;
      for (int i = 0; i < N_CH; i++) cmp_r[i] <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: begin
          sel2_q <= bus_wdata[M_SEL2];
          csrc_q <= bus_wdata[M_CSRC];
          ie2_q  <= bus_wdata[M_IE2];
        end
        A_BRK:   brk_en_q <= bus_wdata[1:0];
        A_RLD1L: rld1[7:0] <= bus_wdata;
        A_RLD1H: rld1[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
        A_RLD2L: rld2[7:0] <= bus_wdata;
        A_RLD2H: rld2[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
        default: begin
          for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == addr_t'(A_CMP0 + 2*i))
              cmp_r[i][7:0] <= bus_wdata;
            if (bus_addr == addr_t'(A_CMP0 + 2*i + 1))
              cmp_r[i][CNT_W-1:8] <= bus_wdata[HI_W-1:0];
          end
        end
      endcase
    end
  end

  // counter 2 overflow flag: a new wrap wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf2_q <= 1'b0;
    else if (wrap2)   ovf2_q <= 1'b1;
    else if (clr_ovf) ovf2_q <= 1'b0;
  end
  assign ovf2_irq = ovf2_q && ie2_q;

  pwmt_counter #(.W(CNT_W)) i_cnt1 (
    .clk(clk), .rst_n(rst_n), .en(1'b1),
    .force_set(wr_mode && bus_wdata[M_FRC1]), .reload(rld1),
    .cnt_o(cnt1), .wrap_o(wrap1), .force_o(frc1));

  pwmt_counter #(.W(CNT_W)) i_cnt2 (
    .clk(clk), .rst_n(rst_n), .en(sel2_q),
    .force_set(wr_mode && bus_wdata[M_FRC2]), .reload(rld2),
    .cnt_o(cnt2), .wrap_o(wrap2), .force_o(frc2));

  pwmt_capture #(.W(CNT_W), .NPIN(2)) i_cap (
    .clk(clk), .rst_n(rst_n), .pins({lcap_pin, cap_pin}), .src(csrc_q),
    .cnt(cnt1), .clr(clr_cap), .cap_o(cap_val), .flag_o(cap_flag));

  // break routing per pair
  logic brk_p0, brk_p1;
  assign brk_p0 = brk_in && brk_en_q[0];
  assign brk_p1 = brk_in && (sel2_q ? brk_en_q[1] : brk_en_q[0]);

  logic [N_CH-1:0] ch_q;
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CNT_W-1:0] base;
    if (i < HALF) begin : g_p0
      assign base     = cnt1;
      assign pwm_o[i] = ch_q[i] && !brk_p0;
    end else begin : g_p1
      assign base     = sel2_q ? cnt2 : cnt1;
      assign pwm_o[i] = ch_q[i] && !brk_p1;
    end
    pwmt_pwm_ch #(.W(CNT_W)) i_ch (
      .clk(clk), .rst_n(rst_n), .cnt(base), .cmp(cmp_r[i]), .out_q(ch_q[i]));
  end

  // read path
  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MODE:  rd_mux = {2'b00, frc2, frc1, ovf2_q, ie2_q, csrc_q, sel2_q};
      A_BRK:   rd_mux = {6'b0, brk_en_q};
      A_RLD1L: rd_mux = rld1[7:0];
      A_RLD1H: rd_mux = hi8(rld1);
      A_RLD2L: rd_mux = rld2[7:0];
      A_RLD2H: rd_mux = hi8(rld2);
      A_CAPL:  rd_mux = cap_val[7:0];
      A_CAPH:  rd_mux = hi8(cap_val) | {cap_flag, 7'b0};
      A_CNT2L: rd_mux = cnt2[7:0];
      A_CNT2H: rd_mux = hi8(cnt2);
      default: begin
        for (int i = 0; i < N_CH; i++) begin
          if (bus_addr == addr_t'(A_CMP0 + 2*i))     rd_mux = cmp_r[i][7:0];
          if (bus_addr == addr_t'(A_CMP0 + 2*i + 1)) rd_mux = hi8(cmp_r[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9
  brk_pair0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_in && brk_en_q[0]) |-> pwm_o[HALF-1:0] == '0);
  // R9
  brk_pair1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_in && (sel2_q ? brk_en_q[1] : brk_en_q[0])) |-> pwm_o[N_CH-1:HALF] == '0);
  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap2 |=> ovf2_q);
  // R3
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !wrap2) |=> !ovf2_q);
  // R4
  frozen_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel2_q && !frc2) |=> $stable(cnt2));
  // R7
  cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cap && cap_flag) |=> !cap_flag || $changed(cap_val));
endmodule

// File: tb/test_pwmt_timer.sv
module test_pwmt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0, lcap_pin = 1'b0, brk_in = 1'b0;
  logic [3:0] pwm_o;
  logic       ovf2_irq;
  int         checks = 0, errors = 0, cyc = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwmt_timer i_pwmt_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .lcap_pin(lcap_pin), .brk_in(brk_in),
    .pwm_o(pwm_o), .ovf2_irq(ovf2_irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_cnt2(output int v);
    logic [7:0] lo, hi;
    rd(5'h10, lo);
    rd(5'h11, hi);
    v = {hi[3:0], lo};
  endtask

  task automatic measure(output int c0, output int c1, output int c2, output int c3);
    c0 = 0; c1 = 0; c2 = 0; c3 = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      c0 += pwm_o[0]; c1 += pwm_o[1]; c2 += pwm_o[2]; c3 += pwm_o[3];
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R10 pwm after reset", pwm_o, 0);
    chk("R10 irq after reset", ovf2_irq, 0);
    rd(5'h00, d); chk("R10 mode", d, 0);
    rd(5'h01, d); chk("R8 brk reset", d, 8'h03);
    rd(5'h07, d); chk("R10 cap hi and flag", d, 0);
    rd(5'h06, d); chk("R10 cap lo", d, 0);
  endtask

  task automatic t_capture;
    logic [7:0] h, l;
    int t1, v1, v3;
    @(negedge clk); cap_pin = 1'b1; t1 = cyc;
    repeat (20) @(negedge clk);
    cap_pin = 1'b0;                      // falling edge while flag set
    repeat (10) @(negedge clk);
    rd(5'h07, h);
    chk("R6 flag after rising edge", h[7], 1);
    rd(5'h06, l);
    v1 = {h[3:0], l};
    rd(5'h07, h);
    chk("R7 flag cleared by low read", h[7], 0);
    while (cyc < t1 + 100) @(negedge clk);
    cap_pin = 1'b1;
    repeat (10) @(negedge clk);
    rd(5'h07, h); rd(5'h06, l);
    v3 = {h[3:0], l};
    chk("R7 edge ignored while flag set", (v3 - v1) & 12'hFFF, 100);
    // source select
    wr(5'h00, 8'h02);
    @(negedge clk); cap_pin = 1'b0;
    repeat (10) @(negedge clk);
    rd(5'h07, h);
    chk("R6 unselected pin ignored", h[7], 0);
    @(negedge clk); lcap_pin = 1'b1;
    repeat (10) @(negedge clk);
    rd(5'h07, h);
    chk("R6 long pin captures", h[7], 1);
    rd(5'h06, l);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_freeze;
    int a, b, c;
    wr(5'h00, 8'h01);
    repeat (30) @(negedge clk);
    wr(5'h00, 8'h00);
    rd_cnt2(a);
    chk("R1 counter 2 advanced", (a >= 30 && a < 60), 1);
    repeat (50) @(negedge clk);
    rd_cnt2(b);
    chk("R4 counter 2 frozen", b, a);
    wr(5'h00, 8'h01);
    repeat (20) @(negedge clk);
    rd_cnt2(c);
    chk("R4 counter 2 resumes from held", (c > a && c < a + 40), 1);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_force;
    logic [7:0] d;
    int v;
    wr(5'h04, 8'h00); wr(5'h05, 8'h01);   // reload 2 = 0x100
    wr(5'h00, 8'h20);                      // force counter 2, frozen
    rd(5'h00, d);
    chk("R2 force bit set", d[5], 1);
    rd_cnt2(v);
    chk("R2 force loads 0xFFF", v, 12'hFFF);
    wr(5'h00, 8'h00);
    rd(5'h00, d);
    chk("R2 write 0 keeps force", d[5], 1);
    wr(5'h00, 8'h01);
    repeat (5) @(negedge clk);
    rd(5'h00, d);
    chk("R2 force cleared after overflow", d[5], 0);
    chk("R3 overflow flag set", d[3], 1);
    rd(5'h00, d);
    chk("R3 flag cleared by read", d[3], 0);
    rd_cnt2(v);
    chk("R1 counter 2 reloaded", (v >= 12'h100 && v < 12'h120), 1);
  endtask

  task automatic t_irq_and_pwm;
    logic [7:0] d;
    int c0, c1, c2, c3;
    wr(5'h02, 8'h00); wr(5'h03, 8'h0F);   // reload 1 = 0xF00
    wr(5'h04, 8'h80); wr(5'h05, 8'h0F);   // reload 2 = 0xF80
    wr(5'h08, 8'h40); wr(5'h09, 8'h0F);   // cmp0 = 0xF40
    wr(5'h0A, 8'h00); wr(5'h0B, 8'h00);   // cmp1 = 0
    wr(5'h0C, 8'hFF); wr(5'h0D, 8'h0F);   // cmp2 = 0xFFF
    wr(5'h0E, 8'hC0); wr(5'h0F, 8'h0F);   // cmp3 = 0xFC0
    wr(5'h00, 8'h05);                      // counter 2 selected, irq enabled
    repeat (4200) @(negedge clk);
    chk("R3 irq raised", ovf2_irq, 1);
    rd(5'h00, d);
    chk("R3 flag read", d[3], 1);
    chk("R3 irq drops after read", ovf2_irq, 0);
    measure(c0, c1, c2, c3);
    chk("R5 pwm0 quarter", c0, 64);
    chk("R5 pwm1 zero compare", c1, 0);
    chk("R4 pwm2 full from counter 2", c2, 254);
    chk("R4 pwm3 from counter 2", c3, 128);
    wr(5'h00, 8'h00);
    repeat (4) @(negedge clk);
    measure(c0, c1, c2, c3);
    chk("R5 pwm2 full from counter 1", c2, 255);
    chk("R4 pwm3 from counter 1", c3, 192);
  endtask

  task automatic t_break;
    logic [7:0] d;
    int c0, c1, c2, c3;
    wr(5'h00, 8'h01);
    @(negedge clk); brk_in = 1'b1;
    repeat (2) @(negedge clk);
    measure(c0, c1, c2, c3);
    chk("R9 both enables block all", c0 + c2 + c3, 0);
    wr(5'h01, 8'h02);
    repeat (2) @(negedge clk);
    measure(c0, c1, c2, c3);
    chk("R9 en2 only leaves pair0", c0, 64);
    chk("R9 en2 blocks pair1 on counter 2", c3, 0);
    wr(5'h00, 8'h00);
    repeat (4) @(negedge clk);
    measure(c0, c1, c2, c3);
    chk("R9 en2 ignored when pair1 on counter 1", c3, 192);
    wr(5'h01, 8'h01); wr(5'h00, 8'h01);
    repeat (4) @(negedge clk);
    measure(c0, c1, c2, c3);
    chk("R9 en1 blocks pair0", c0, 0);
    chk("R9 en1 ignored for pair1 on counter 2", c3, 128);
    @(negedge clk); brk_in = 1'b0;
    wr(5'h01, 8'hFF);
    rd(5'h01, d);
    chk("R8 reserved bits read 0", d, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_capture;
    t_freeze;
    t_force;
    t_irq_and_pwm;
    t_break;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule